// File: doc/BRIEF.md
# ID-Ordered Transaction Routing Tracker

This block sits on the request side of a bus demultiplexer that fans one requester out to several destination ports. For each incoming request it decides, in the same cycle, whether the request may be accepted. The inputs are the request's ID, its destination port and whether it is a read or a write. Responses come back through a per-direction completion strobe that carries an ID. The block has no reorder storage. It keeps responses for one ID in order by holding back any request that would send that ID to a second destination while older transactions with the same ID are still open.

Reads and writes each have their own table. Each table has one entry per tracked ID. An entry holds the destination of the open transactions and a count of how many there are. Each table also keeps a total of all its open transactions, and that total is capped. Only the low `ID_USED` bits of an ID select an entry. A completion for an entry whose count is already zero is reported on an error output.

Top module: `id_order_tracker`

## Requirements
- R1: After reset every entry is free. A request in either direction, with any ID and any destination, is accepted, and `bad_done` is low.
- R2: A request is stalled (`req_ready` low) when its entry, in its own direction, has a nonzero count and the stored destination differs from `req_dest`.
- R3: A request whose entry has a nonzero count and a matching destination is accepted in the same cycle, as long as the cap is not reached.
- R4: Once an entry's count has drained to zero, the next request for that ID is accepted to any destination.
- R5: Reads (`req_is_write`=0) and writes (`req_is_write`=1) use separate tables. Traffic in one direction never stalls the other.
- R6: Each direction holds at most `MAX_TXNS` open transactions (default 4). While a direction's total equals `MAX_TXNS`, every request in that direction is stalled.
- R7: An accepted request and a completion for the same entry in the same cycle leave that entry's count unchanged.
- R8: A completion whose entry count is zero drives `bad_done` high in that same cycle and changes no state.
- R9: Entries are selected by `id[ID_USED-1:0]` (default 2 bits). IDs that differ only in higher bits share one entry.
- R10: `req_ready` is low whenever `req_valid` is low, and a request is taken in a cycle only when `req_valid` and `req_ready` are both high at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_id | input | ID_W | Transaction ID of the request |
| req_dest | input | DEST_W | Destination port chosen for the request |
| req_is_write | input | 1 | 1 = write request, 0 = read request |
| req_ready | output | 1 | Request accepted this cycle (low = stall) |
| rd_done_valid | input | 1 | A read transaction completed |
| rd_done_id | input | ID_W | ID of the completed read |
| wr_done_valid | input | 1 | A write transaction completed |
| wr_done_id | input | ID_W | ID of the completed write |
| bad_done | output | 1 | A completion arrived for an entry with a zero count |

## Verification
The bench goes after these corner cases:

- **Release on the last completion.** A design that frees an entry one completion early would let an ID switch destinations while an older response is still pending. One that never frees it would stall that ID forever.
- **Request and completion on the same entry in one cycle.** A design that drops either update leaves the count off by one, and the ID then frees too early or too late.
- **Aliasing and direction separation.** If the high ID bits or the direction bit leak into the table index, two requests that should conflict pass each other, or two that should be independent block each other.
- **The cap and the zero-count completion.** An off-by-one at the cap lets a fifth transaction in. A completion on an idle entry that still decrements would wrap the counters.

A long pseudo-random sweep of IDs, destinations and completions then compares every cycle against an arithmetic model kept in the bench.

// File: rtl/id_order_pkg.sv
`timescale 1ns/1ps
package id_order_pkg;
  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } dir_e;

  localparam int unsigned NUM_DIRS = 2;
endpackage

// File: rtl/ido_entry.sv
`timescale 1ns/1ps
module ido_entry #(
  parameter int unsigned DEST_W   = 2,
  parameter int unsigned MAX_TXNS = 4,
  parameter int unsigned CNT_W    = $clog2(MAX_TXNS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  input  logic              dec_i,
  input  logic [DEST_W-1:0] dest_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DEST_W-1:0] dest_o
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_TXNS);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DEST_W-1:0] dest_q;
  logic              dest_en;

  always_comb begin
    cnt_d   = cnt_q;
    dest_en = inc_i;
    case ({inc_i, dec_i})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dest_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (dest_en) dest_q <= dest_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign dest_o = dest_q;

  // R2: an open entry only ever takes more requests for its own destination
  a_r2_dest_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && inc_i) |-> (dest_i == dest_q));
  // R7: simultaneous take and completion keep the count
  a_r7_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && dec_i) |=> $stable(cnt_q));
  // R6: a single entry never holds more than the cap
  a_r6_entry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAX_C);
endmodule

// File: rtl/ido_table.sv
`timescale 1ns/1ps
module ido_table #(
  parameter int unsigned IDX_W    = 2,
  parameter int unsigned DEST_W   = 2,
  parameter int unsigned MAX_TXNS = 4,
  parameter int unsigned CNT_W    = $clog2(MAX_TXNS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  chk_idx_i,
  input  logic [DEST_W-1:0] chk_dest_i,
  input  logic              push_i,
  input  logic              pop_valid_i,
  input  logic [IDX_W-1:0]  pop_idx_i,
  output logic              allow_o,
  output logic              err_o
);
  localparam int unsigned      N_ENT = 1 << IDX_W;
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_TXNS);

  logic [CNT_W-1:0]  cnt_w  [N_ENT];
  logic [DEST_W-1:0] dest_w [N_ENT];
  logic [CNT_W-1:0]  total_q, total_d;
  logic              pop_ok;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic inc, dec;
    assign inc = push_i && (chk_idx_i == IDX_W'(i));
    assign dec = pop_ok && (pop_idx_i == IDX_W'(i));
    ido_entry #(
      .DEST_W   (DEST_W),
      .MAX_TXNS (MAX_TXNS),
      .CNT_W    (CNT_W)
    ) u_ent (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc_i  (inc),
      .dec_i  (dec),
      .dest_i (chk_dest_i),
      .cnt_o  (cnt_w[i]),
      .dest_o (dest_w[i])
    );
  end

  always_comb begin
    err_o   = pop_valid_i && (cnt_w[pop_idx_i] == '0);
    pop_ok  = pop_valid_i && !err_o;
    allow_o = (total_q < MAX_C) &&
              ((cnt_w[chk_idx_i] == '0) || (dest_w[chk_idx_i] == chk_dest_i));
    total_d = total_q;
    case ({push_i, pop_ok})
      2'b10:   total_d = total_q + CNT_W'(1);
      2'b01:   total_d = total_q - CNT_W'(1);
      default: total_d = total_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) total_q <= '0;
    else        total_q <= total_d;
  end

  // R6: total open transactions stay within the cap
  a_r6_total_cap: assert property (@(posedge clk) disable iff (!rst_n)
    total_q <= MAX_C);
  // R8: a completion on an idle entry leaves the total alone
  a_r8_idle_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !push_i) |=> $stable(total_q));
endmodule

// File: rtl/id_order_tracker.sv
`timescale 1ns/1ps
module id_order_tracker #(
  parameter int unsigned ID_W     = 4,
  parameter int unsigned ID_USED  = 2,
  parameter int unsigned DEST_W   = 2,
  parameter int unsigned MAX_TXNS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic [DEST_W-1:0] req_dest,
  input  logic              req_is_write,
  output logic              req_ready,
  input  logic              rd_done_valid,
  input  logic [ID_W-1:0]   rd_done_id,
  input  logic              wr_done_valid,
  input  logic [ID_W-1:0]   wr_done_id,
  output logic              bad_done
);
  import id_order_pkg::*;

  localparam int unsigned CNT_W = $clog2(MAX_TXNS + 1);

  logic [NUM_DIRS-1:0] allow, push, pop_v, err;
  logic [ID_USED-1:0]  pop_idx [NUM_DIRS];
  dir_e                req_dir;

  assign req_dir    = dir_e'(req_is_write);
  assign pop_v[0]   = rd_done_valid;
  assign pop_v[1]   = wr_done_valid;
  assign pop_idx[0] = rd_done_id[ID_USED-1:0];
  assign pop_idx[1] = wr_done_id[ID_USED-1:0];

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    assign push[d] = req_valid && (req_dir == dir_e'(d)) && allow[d];
    ido_table #(
      .IDX_W    (ID_USED),
      .DEST_W   (DEST_W),
      .MAX_TXNS (MAX_TXNS),
      .CNT_W    (CNT_W)
    ) u_tab (
      .clk         (clk),
      .rst_n       (rst_n),
      .chk_idx_i   (req_id[ID_USED-1:0]),
      .chk_dest_i  (req_dest),
      .push_i      (push[d]),
      .pop_valid_i (pop_v[d]),
      .pop_idx_i   (pop_idx[d]),
      .allow_o     (allow[d]),
      .err_o       (err[d])
    );
  end

  if (ID_W > ID_USED) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^{req_id[ID_W-1:ID_USED], rd_done_id[ID_W-1:ID_USED],
                         wr_done_id[ID_W-1:ID_USED]};
  end

  assign req_ready = |push;
  assign bad_done  = |err;

  // R5: a request lands in exactly one direction table
  a_r5_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(push));
  // R10: no request is taken without req_valid
  a_r10_valid_gate: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);
endmodule

// File: tb/sim_id_order_tracker.sv
`timescale 1ns/1ps
module sim_id_order_tracker;
  localparam int MAXT = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_is_write, rd_done_valid, wr_done_valid;
  logic [3:0] req_id, rd_done_id, wr_done_id;
  logic [1:0] req_dest;
  logic       req_ready, bad_done;

  int total_n = 0;
  int fail_n  = 0;
  bit finished = 0;
  int cnt_m [2][4];
  int dst_m [2][4];
  int tot_m [2];

  always #2.5 clk = ~clk;

  id_order_tracker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_dest(req_dest), .req_is_write(req_is_write), .req_ready(req_ready),
    .rd_done_valid(rd_done_valid), .rd_done_id(rd_done_id),
    .wr_done_valid(wr_done_valid), .wr_done_id(wr_done_id), .bad_done(bad_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total_n++;
    if (act != exp) begin
      fail_n++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check before the edge, update the model after it
  task automatic step(input string tag, input bit v, input int id, input int d,
                      input bit wr, input bit rv, input int rid, input bit wv,
                      input int wid, input bit commit);
    int  dir, ix, ri, wi;
    bit  exp_rdy, exp_err, pop_r, pop_w;
    @(negedge clk);
    req_valid = v; req_id = 4'(id); req_dest = 2'(d); req_is_write = wr;
    rd_done_valid = rv; rd_done_id = 4'(rid);
    wr_done_valid = wv; wr_done_id = 4'(wid);
    #1;
    dir = wr ? 1 : 0; ix = id % 4; ri = rid % 4; wi = wid % 4;
    exp_rdy = v && (tot_m[dir] < MAXT) && (cnt_m[dir][ix] == 0 || dst_m[dir][ix] == d);
    pop_r = rv && cnt_m[0][ri] > 0;
    pop_w = wv && cnt_m[1][wi] > 0;
    exp_err = (rv && !pop_r) || (wv && !pop_w);
    chk({tag, " ready"}, int'(req_ready), int'(exp_rdy));
    chk({tag, " bad_done"}, int'(bad_done), int'(exp_err));
    if (!commit) begin
      req_valid = 0; rd_done_valid = 0; wr_done_valid = 0;
    end
    @(posedge clk);
    if (commit) begin
      if (pop_r) begin cnt_m[0][ri]--; tot_m[0]--; end
      if (pop_w) begin cnt_m[1][wi]--; tot_m[1]--; end
      if (exp_rdy) begin cnt_m[dir][ix]++; dst_m[dir][ix] = d; tot_m[dir]++; end
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total_n - fail_n, total_n);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      total_n++; fail_n++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    for (int d = 0; d < 2; d++) begin
      tot_m[d] = 0;
      for (int i = 0; i < 4; i++) begin cnt_m[d][i] = 0; dst_m[d][i] = 0; end
    end
    rst_n = 0; req_valid = 0; req_id = 0; req_dest = 0; req_is_write = 0;
    rd_done_valid = 0; rd_done_id = 0; wr_done_valid = 0; wr_done_id = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 / R10: reset state and an idle request line
    step("R10 idle", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R1: every id, destination and direction is free after reset (probe only)
    for (int w = 0; w < 2; w++)
      for (int id = 0; id < 16; id++)
        for (int d = 0; d < 4; d++)
          step("R1 free", 1, id, d, w[0], 0, 0, 0, 0, 0);

    // R3 / R2 / R5 / R9
    step("R3 first", 1, 1, 2, 0, 0, 0, 0, 0, 1);
    step("R2 other dest", 1, 1, 3, 0, 0, 0, 0, 0, 0);
    step("R5 write same id", 1, 1, 3, 1, 0, 0, 0, 0, 0);
    step("R9 alias stall", 1, 5, 3, 0, 0, 0, 0, 0, 0);
    step("R9 alias same dest", 1, 5, 2, 0, 0, 0, 0, 0, 1);
    // R7: take and complete the same entry in one cycle, count stays 2
    step("R7 take+done", 1, 1, 2, 0, 1, 9, 0, 0, 1);
    step("R7 drain1", 0, 0, 0, 0, 1, 1, 0, 0, 1);
    step("R4 still open", 1, 1, 0, 0, 0, 0, 0, 0, 0);
    step("R7 drain2", 0, 0, 0, 0, 1, 13, 0, 0, 1);
    step("R4 any dest", 1, 1, 0, 0, 0, 0, 0, 0, 0);
    // R8: completions on idle entries
    step("R8 rd idle", 0, 0, 0, 0, 1, 1, 0, 0, 1);
    step("R8 wr idle", 0, 0, 0, 0, 0, 0, 1, 2, 1);
    step("R8 no effect", 1, 1, 3, 0, 0, 0, 0, 0, 0);
    // R6: fill reads to the cap
    for (int i = 0; i < 4; i++) step("R6 fill", 1, i, 1, 0, 0, 0, 0, 0, 1);
    step("R6 cap stall", 1, 2, 1, 0, 0, 0, 0, 0, 0);
    step("R5 write free at read cap", 1, 2, 0, 1, 0, 0, 0, 0, 1);
    step("R6 release", 1, 3, 1, 0, 1, 0, 0, 0, 1);
    step("R6 cap again", 1, 3, 1, 0, 0, 0, 0, 0, 0);

    // sweep: pseudo-random mix against the bench model (R2 R3 R4 R6 R7 R8 R9)
    lf = 32'h1234_5678;
    for (int n = 0; n < 4000; n++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      step("R2/R3/R6 sweep", lf[0], int'(lf[4:1]), int'(lf[6:5]), lf[7],
           lf[10:8] < 3'd3, int'(lf[14:11]), lf[17:15] < 3'd3, int'(lf[21:18]), 1);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule